// File: doc/BRIEF.md
# Debounced Eight-Input Serializer with CRC Status Word

This block models one serializing input chip seen from the controller's side. It captures eight digital field inputs and presents them on a serial peripheral interface (chip select, serial clock, data in, data out). Each input line is filtered by a debounce stage whose length is chosen by two select pins. A captured snapshot is taken when chip select falls. While chip select stays low, each serial clock falling edge shifts the snapshot toward the data-out pin.

Two word formats are available. With the mode pin high, the word is just the input byte. With the mode pin low, a status byte follows the input byte. The status byte holds a 5-bit CRC of the captured byte and three supply and temperature flags. Data arriving on the serial input is passed along behind the local word, so several chips wired in a chain appear to the controller as consecutive words.

Undervoltage, undervoltage-warning and overtemperature conditions arrive as digital inputs. A registered fault output reports whether any alarm is present.

Top module: `field_input_serializer`

## Requirements
- R1: With `mode8` high, the first 8 bits on `sdo` after chip select falls are the debounced inputs, most significant bit first.
- R2: With `mode8` low, the frame is 16 bits: the input byte followed by the status byte, each MSB first.
- R3: Status bits [7:3] hold the CRC of the input byte. The CRC uses polynomial x^5+x^4+x^2+1, runs MSB first and starts from zero.
- R4: Status bit 2 is 0 when `uv_alarm` is high. Status bit 1 equals `ot_alarm`. Status bit 0 is 0 when `uv_warn` is high. All three are taken at the moment chip select falls.
- R5: Serial input bits taken at rising clock edges reappear on `sdo` exactly one word length (8 or 16 bits) later, after the local word.
- R6: Input changes while chip select is low do not alter the word being shifted; the next frame carries them.
- R7: `db_sel` 00 passes inputs with no filtering. 01, 10 and 11 require an input to be stable for 16, 64 and 256 clock cycles before its captured value changes.
- R8: A pulse shorter than the selected debounce window leaves the captured value unchanged.
- R9: `fault` is high one cycle after `uv_alarm` or `ot_alarm` is high, and low one cycle after both are low.
- R10: After reset, and whenever chip select is high, `sdo` is 0 and `fault` starts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from the upstream chip |
| sdo | output | 1 | Serial data toward the controller |
| din | input | 8 | Field input lines |
| mode8 | input | 1 | High: byte-only frame; low: byte plus status |
| db_sel | input | 2 | Debounce window select |
| uv_alarm | input | 1 | Undervoltage alarm condition, active high |
| uv_warn | input | 1 | Undervoltage warning condition, active high |
| ot_alarm | input | 1 | Overtemperature condition, active high |
| fault | output | 1 | Registered OR of the alarm conditions |

## Verification
The bench covers the point where the local word ends and upstream data begins, in both word lengths. A chain offset off by one shows up there as a bit slip across the whole tail.

CRC and flag polarity are checked against an independent long-division remainder over several bytes. An inverted active-low flag or a reflected CRC therefore gives a wrong status byte.

Debounce is tested just inside and well past each window, and with a short glitch. A design that counted from the wrong edge, or did not reset its count on a glitch, would show the new value too early.

A mid-frame input change targets designs that sample live inputs instead of the snapshot.

// File: rtl/fis_pkg.sv
package fis_pkg;
  typedef enum logic [1:0] {
    DB_OFF   = 2'b00,
    DB_SHORT = 2'b01,
    DB_MID   = 2'b10,
    DB_LONG  = 2'b11
  } db_mode_e;

  localparam logic [4:0] CRC_POLY = 5'h15;

  // Serial CRC, MSB first, zero seed
  function automatic logic [4:0] crc5_msb(input logic [7:0] d);
    logic [4:0] c;
    logic fb;
    c = '0;
    for (int i = 7; i >= 0; i--) begin
      fb = c[4] ^ d[i];
      c  = {c[3:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/fis_sync.sv
module fis_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fis_debounce.sv
module fis_debounce
  import fis_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int LIM_SHORT = 16,
  parameter int LIM_MID = 64,
  parameter int LIM_LONG = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] cap
);
  localparam int CW = $clog2(LIM_LONG + 1);

  logic [CW-1:0] lim_m1;

  always_comb begin
    case (db_mode_e'(sel))
      DB_SHORT: lim_m1 = CW'(LIM_SHORT - 1);
      DB_MID:   lim_m1 = CW'(LIM_MID - 1);
      DB_LONG:  lim_m1 = CW'(LIM_LONG - 1);
      default:  lim_m1 = '0;
    endcase
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt    <= '0;
        cap[i] <= 1'b0;
      end else if (db_mode_e'(sel) == DB_OFF) begin
        cnt    <= '0;
        cap[i] <= raw[i];
      end else if (raw[i] == cap[i]) begin
        cnt <= '0;
      end else if (cnt == lim_m1) begin
        cnt    <= '0;
        cap[i] <= raw[i];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fis_shifter.sv
module fis_shifter #(
  parameter int WORD = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            idle,
  input  logic            load,
  input  logic            sck_rise,
  input  logic            sck_fall,
  input  logic            sdi_s,
  input  logic            mode8,
  input  logic [WORD-1:0] word,
  output logic [WORD-1:0] shreg
);
  localparam int HALF = WORD / 2;

  logic            sdi_lat;
  logic [WORD-1:0] nxt;

  always_comb begin
    nxt = {shreg[WORD-2:0], 1'b0};
    if (mode8) nxt[HALF] = sdi_lat;
    else       nxt[0]    = sdi_lat;
  end

  always_ff @(posedge clk) begin
    if (rst || idle) begin
      shreg   <= '0;
      sdi_lat <= 1'b0;
    end else if (load) begin
      shreg <= word;
    end else if (sck_rise) begin
      sdi_lat <= sdi_s;
    end else if (sck_fall) begin
      shreg <= nxt;
    end
  end
endmodule

// File: rtl/field_input_serializer.sv
module field_input_serializer
  import fis_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DB_CNT_SHORT = 16,
  parameter int DB_CNT_MID = 64,
  parameter int DB_CNT_LONG = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  input  logic [7:0] din,
  input  logic       mode8,
  input  logic [1:0] db_sel,
  input  logic       uv_alarm,
  input  logic       uv_warn,
  input  logic       ot_alarm,
  output logic       fault
);
  localparam int NIN = 8;
  localparam int WORD = 2 * NIN;

  logic [2:0]     ser_s;
  logic           cs_s, sck_s, sdi_s;
  logic           cs_d, sck_d;
  logic           cs_idle, load, sck_rise, sck_fall;
  logic [NIN-1:0] din_s, din_cap;
  logic [7:0]     status;
  logic [WORD-1:0] word, shreg;

  fis_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_ser_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdi}), .q(ser_s)
  );
  assign {cs_s, sck_s, sdi_s} = ser_s;

  fis_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_din_sync (
    .clk(clk), .rst(rst), .d(din), .q(din_s)
  );

  fis_debounce #(
    .WIDTH(NIN), .LIM_SHORT(DB_CNT_SHORT), .LIM_MID(DB_CNT_MID), .LIM_LONG(DB_CNT_LONG)
  ) u_db (
    .clk(clk), .rst(rst), .sel(db_sel), .raw(din_s), .cap(din_cap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
      fault <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
      fault <= uv_alarm | ot_alarm;
    end
  end

  assign cs_idle  = cs_s;
  assign load     = cs_d & ~cs_s;
  assign sck_rise = ~cs_s & ~sck_d & sck_s;
  assign sck_fall = ~cs_s & sck_d & ~sck_s;

  // crc[7:3], uv alarm (low active), overtemp, uv warning (low active)
  assign status = {crc5_msb(din_cap), ~uv_alarm, ot_alarm, ~uv_warn};
  assign word   = {din_cap, status};

  fis_shifter #(.WORD(WORD)) u_shift (
    .clk(clk), .rst(rst), .idle(cs_idle), .load(load),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_s(sdi_s),
    .mode8(mode8), .word(word), .shreg(shreg)
  );

  assign sdo = shreg[WORD-1];
endmodule

// File: rtl/fis_checker.sv
module fis_checker
  import fis_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        uv_alarm,
  input logic        uv_warn,
  input logic        ot_alarm,
  input logic        fault,
  input logic        sdo,
  input logic        mode8,
  input logic [1:0]  db_sel,
  input logic [7:0]  din_s,
  input logic [7:0]  din_cap,
  input logic        cs_idle,
  input logic        load,
  input logic        sck_fall,
  input logic [15:0] shreg
);
  AST_BYTE_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> shreg[15:8] == $past(din_cap)); // R1
  AST_CRC_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load && !mode8) |=> shreg[7:3] == crc5_msb($past(din_cap))); // R3
  AST_FLAGS_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load && !mode8) |=> shreg[2:0] == {~$past(uv_alarm), $past(ot_alarm), ~$past(uv_warn)}); // R4
  AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!cs_idle && !load && !sck_fall) |=> $stable(shreg)); // R6
  AST_DB_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (db_sel == 2'b00) |=> din_cap == $past(din_s)); // R7
  AST_DB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (db_sel != 2'b00 && din_s == din_cap) |=> $stable(din_cap)); // R8
  AST_FAULT_SET: assert property (@(posedge clk) disable iff (rst)
    (uv_alarm || ot_alarm) |=> fault); // R9
  AST_FAULT_CLR: assert property (@(posedge clk) disable iff (rst)
    (!uv_alarm && !ot_alarm) |=> !fault); // R9
  AST_IDLE_SDO_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !sdo); // R10
endmodule

bind field_input_serializer fis_checker u_chk (
  .clk(clk), .rst(rst), .uv_alarm(uv_alarm), .uv_warn(uv_warn),
  .ot_alarm(ot_alarm), .fault(fault), .sdo(sdo), .mode8(mode8),
  .db_sel(db_sel), .din_s(din_s), .din_cap(din_cap), .cs_idle(cs_idle),
  .load(load), .sck_fall(sck_fall), .shreg(shreg)
);

// File: tb/field_input_serializer_tb_top.sv
`timescale 1ns/1ps
module field_input_serializer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, fault;
  logic [7:0] din = '0;
  logic mode8 = 1'b1;
  logic [1:0] db_sel = 2'b00;
  logic uv_alarm = 1'b0, uv_warn = 1'b0, ot_alarm = 1'b0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  field_input_serializer dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .din(din), .mode8(mode8), .db_sel(db_sel), .uv_alarm(uv_alarm),
    .uv_warn(uv_warn), .ot_alarm(ot_alarm), .fault(fault)
  );

  // data[43:36] mode8[35] uv[34] ot[33] warn[32] upstream[31:0]
  localparam int NVEC = 6;
  localparam logic [43:0] VEC [NVEC] = '{
    {8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 32'h3C96_F00F},
    {8'h01, 1'b1, 1'b1, 1'b1, 1'b1, 32'hFFFF_0000},
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5678},
    {8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF},
    {8'h80, 1'b0, 1'b0, 1'b1, 1'b1, 32'h8001_8001},
    {8'h3C, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0F0F_5AA5}
  };

  // Remainder of data * x^5 divided by x^5+x^4+x^2+1 (long division)
  function automatic logic [4:0] ref_crc(input logic [7:0] d);
    logic [12:0] r;
    r = {d, 5'b0};
    for (int b = 12; b >= 5; b--)
      if (r[b]) r = r ^ (13'b110101 << (b - 5));
    return r[4:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] up, input bit mid_en, input logic [7:0] mid_val,
                      output logic [31:0] got);
    got = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (10) @(negedge clk);
    for (int b = 0; b < 32; b++) begin
      sdi = up[31-b];
      if (mid_en && b == 4) din = mid_val;
      got[31-b] = sdo;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      repeat (8) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic read_byte(output logic [7:0] b);
    logic [31:0] g;
    xfer(32'h0, 1'b0, 8'h00, g);
    b = g[31:24];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, exp;
    logic [7:0] byt, st;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 sdo after reset", {31'b0, sdo}, 32'h0);
    chk("R10 fault after reset", {31'b0, fault}, 32'h0);

    // Vector table: R1 R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      din = VEC[v][43:36]; mode8 = VEC[v][35];
      uv_alarm = VEC[v][34]; ot_alarm = VEC[v][33]; uv_warn = VEC[v][32];
      db_sel = 2'b00;
      repeat (6) @(negedge clk);
      xfer(VEC[v][31:0], 1'b0, 8'h00, got);
      if (VEC[v][35]) begin
        exp = {VEC[v][43:36], 24'h0} | (VEC[v][31:0] >> 8);
        chk("R1/R5 byte frame", got, exp);
      end else begin
        st = {ref_crc(VEC[v][43:36]), ~VEC[v][34], VEC[v][33], ~VEC[v][32]};
        exp = {VEC[v][43:36], st, 16'h0} | (VEC[v][31:0] >> 16);
        chk("R2/R3/R4/R5 status frame", got, exp);
      end
    end
    uv_alarm = 1'b0; ot_alarm = 1'b0; uv_warn = 1'b0; mode8 = 1'b1;

    // R9 fault output
    @(negedge clk) ot_alarm = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 fault on overtemp", {31'b0, fault}, 32'h1);
    ot_alarm = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 fault clears", {31'b0, fault}, 32'h0);
    uv_alarm = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 fault on undervoltage", {31'b0, fault}, 32'h1);
    uv_alarm = 1'b0;

    // R6 input change mid-frame
    din = 8'h5A;
    repeat (6) @(negedge clk);
    xfer(32'h0, 1'b1, 8'hC3, got);
    chk("R6 frame keeps snapshot", {24'h0, got[31:24]}, 32'h5A);
    read_byte(byt);
    chk("R6 next frame updated", {24'h0, byt}, 32'hC3);

    // R7 window of 16
    db_sel = 2'b01;
    din = 8'h0F;
    repeat (6) @(negedge clk);
    read_byte(byt);
    chk("R7 16-cycle window not yet elapsed", {24'h0, byt}, 32'hC3);
    repeat (40) @(negedge clk);
    read_byte(byt);
    chk("R7 16-cycle window elapsed", {24'h0, byt}, 32'h0F);

    // R8 short glitch ignored
    din = 8'hF0;
    repeat (10) @(negedge clk);
    din = 8'h0F;
    repeat (40) @(negedge clk);
    read_byte(byt);
    chk("R8 glitch ignored", {24'h0, byt}, 32'h0F);

    // R7 window of 64
    db_sel = 2'b10;
    din = 8'h81;
    repeat (30) @(negedge clk);
    read_byte(byt);
    chk("R7 64-cycle window not yet elapsed", {24'h0, byt}, 32'h0F);
    repeat (80) @(negedge clk);
    read_byte(byt);
    chk("R7 64-cycle window elapsed", {24'h0, byt}, 32'h81);

    // R7 window of 256
    db_sel = 2'b11;
    din = 8'h66;
    repeat (150) @(negedge clk);
    read_byte(byt);
    chk("R7 256-cycle window not yet elapsed", {24'h0, byt}, 32'h81);
    repeat (300) @(negedge clk);
    read_byte(byt);
    chk("R7 256-cycle window elapsed", {24'h0, byt}, 32'h66);

    chk("R10 sdo idle while deselected", {31'b0, sdo}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule